// File: doc/BRIEF.md
# Byte-Packed Speech Coder Peripheral

This block places a 4-bit adaptive differential speech codec behind an 8-bit parallel host port. A host drives a mode select pin and moves data with single-cycle write and read strobes. In compress mode the host writes two 16-bit two's-complement samples as four bytes. It then reads back one byte that carries both 4-bit codes. In expand mode the host writes one byte holding two codes and then reads back the two reconstructed 16-bit samples as four bytes.

A single request line paces the host, which means no data is lost. The line is high when the block can take the next byte or has a result byte waiting. It drops after every strobe and stays low while the codec works. The codec keeps its predicted sample and its step index from one transaction to the next, so a stream must stay in one mode. When the select pin toggles, the codec state is cleared and any half-finished transaction is abandoned.

Top module: `speech_byte_coder`

## Requirements
- R1: Compress transaction: the block accepts four writes in the order sample0 low byte, sample0 high byte, sample1 low byte, sample1 high byte. It then offers one read byte whose bits [3:0] are the code of sample0 and whose bits [7:4] are the code of sample1.
- R2: Expand transaction: the block accepts one write byte and decodes bits [3:0] first, then bits [7:4]. It then offers four reads: decoded sample0 low byte, sample0 high byte, sample1 low byte, sample1 high byte.
- R3: Codec arithmetic. Step index i lies in 0..51 and the step is (4 + i mod 4) shifted left by floor(i/4). Code bit 3 is the sign of the difference. Bits 2, 1 and 0 compare the remaining magnitude against the step, half the step and a quarter of the step. The reconstructed difference is step/8 plus the step, half and quarter selected by bits 2..0. The prediction saturates to the 16-bit signed range. The index falls by 1 when bit 2 is clear and rises by 2·(bits[1:0]+1) when bit 2 is set, clamped to 0..51.
- R4: `sel_decode` low selects compress mode and high selects expand mode.
- R5: Any toggle of `sel_decode` clears the prediction and index to zero and discards any partially written input or unread output. The next transaction starts clean in the new mode.
- R6: `irq` is high when the block is collecting input or holding output. It is low in the cycle after any strobe and low during computation. A result becomes readable, with `irq` high, two cycles after the edge that captured the last input byte.
- R7: A write strobe while output is pending and a read strobe while input is being collected are ignored. `rd_data` is zero whenever no output is pending.
- R8: Codec state carries from one transaction to the next within a mode, so consecutive transactions form one continuous stream.
- R9: During and after synchronous reset the codec state is zero and `rd_data` is zero. `irq` is low during reset and high in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_decode | input | 1 | Mode select: 0 compress, 1 expand |
| wr_stb | input | 1 | Host write strobe, one cycle per byte |
| wr_data | input | 8 | Host write byte |
| rd_stb | input | 1 | Host read strobe, advances to the next result byte |
| rd_data | output | 8 | Current result byte, zero when none pending |
| irq | output | 1 | Service request to the host |

## Verification
The edge that captures a strobe drops `irq` by the next negative clock edge. The bench checks this after every write and read. After the last input byte, the bench samples `irq` low on the next two negative edges and high on the third, matching the two computation cycles. The result byte is then compared at that same negative edge against a scoreboard entry produced by an independent model of the codec. A toggle of the select pin takes effect at the next clock edge. The bench therefore expects `irq` high one negative edge later and reseeds its model to zero at that point.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int SMP_W   = 16;
    localparam int CODE_W  = 4;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 6;
    localparam int IDX_MAX = 51;
    localparam int ENC_IN_BYTES  = 2 * SMP_W / BYTE_W;
    localparam int DEC_OUT_BYTES = ENC_IN_BYTES;
    localparam int CNT_W   = $clog2(ENC_IN_BYTES);

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_CALC0 = 2'd1,
        ST_CALC1 = 2'd2,
        ST_DRAIN = 2'd3
    } seq_t;

    typedef struct packed {
        logic signed [SMP_W-1:0] pred;
        logic [IDX_W-1:0]        idx;
    } codec_st_t;

    function automatic logic [SMP_W-1:0] step_of(input logic [IDX_W-1:0] idx);
        logic [SMP_W-1:0] base;
        base = SMP_W'(4) + {{(SMP_W-2){1'b0}}, idx[1:0]};
        return base << idx[IDX_W-1:2];
    endfunction

    function automatic logic [CODE_W-1:0] enc_code(input codec_st_t s,
                                                   input logic [SMP_W-1:0] smp);
        logic [SMP_W:0] d;
        logic [SMP_W:0] mag;
        logic [SMP_W:0] st;
        logic [CODE_W-1:0] c;
        st   = {1'b0, step_of(s.idx)};
        d    = {smp[SMP_W-1], smp} - {s.pred[SMP_W-1], s.pred};
        c[3] = d[SMP_W];
        mag  = d[SMP_W] ? ((SMP_W+1)'(0) - d) : d;
        c[2] = (mag >= st);
        if (c[2]) mag = mag - st;
        c[1] = (mag >= (st >> 1));
        if (c[1]) mag = mag - (st >> 1);
        c[0] = (mag >= (st >> 2));
        return c;
    endfunction

    function automatic codec_st_t recon(input codec_st_t s, input logic [CODE_W-1:0] c);
        logic [SMP_W-1:0]   st;
        logic signed [17:0] vp;
        logic signed [17:0] p;
        logic [IDX_W:0]     ni;
        codec_st_t          r;
        st = step_of(s.idx);
        vp = $signed({2'b00, st >> 3});
        if (c[2]) vp = vp + $signed({2'b00, st});
        if (c[1]) vp = vp + $signed({2'b00, st >> 1});
        if (c[0]) vp = vp + $signed({2'b00, st >> 2});
        p = $signed({{2{s.pred[SMP_W-1]}}, s.pred});
        p = c[3] ? (p - vp) : (p + vp);
        if (p > 18'sd32767)       r.pred = 16'sh7fff;
        else if (p < -18'sd32768) r.pred = 16'sh8000;
        else                      r.pred = p[SMP_W-1:0];
        if (c[2]) begin
            ni = {1'b0, s.idx} + {{(IDX_W-2){1'b0}}, c[1:0], 1'b0} + (IDX_W+1)'(2);
            if (ni > (IDX_W+1)'(IDX_MAX)) ni = (IDX_W+1)'(IDX_MAX);
        end else begin
            ni = (s.idx == '0) ? '0 : ({1'b0, s.idx} - (IDX_W+1)'(1));
        end
        r.idx = ni[IDX_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/sbc_codec.sv
module sbc_codec
    import sbc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 go,
    input  logic                 dec,
    input  logic [SMP_W-1:0]     smp_in,
    input  logic [CODE_W-1:0]    code_in,
    output logic [CODE_W-1:0]    code_out,
    output logic [SMP_W-1:0]     smp_out,
    output codec_st_t            state_o
);
    codec_st_t st_q, st_n;
    logic [CODE_W-1:0] c;

    always_comb begin
        c        = dec ? code_in : enc_code(st_q, smp_in);
        st_n     = recon(st_q, c);
        code_out = c;
        smp_out  = st_n.pred;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) st_q <= '0;
        else if (go)      st_q <= st_n;
    end

    assign state_o = st_q;
endmodule

// File: rtl/sbc_mode_det.sv
module sbc_mode_det (
    input  logic clk,
    input  logic sel,
    output logic mode_q,
    output logic chg
);
    always_ff @(posedge clk) mode_q <= sel;
    assign chg = (sel != mode_q);
endmodule

// File: rtl/speech_byte_coder.sv
module speech_byte_coder
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_decode,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq
);
    localparam logic [CNT_W-1:0] ENC_LAST_IN  = CNT_W'(ENC_IN_BYTES - 1);
    localparam logic [CNT_W-1:0] DEC_LAST_OUT = CNT_W'(DEC_OUT_BYTES - 1);

    seq_t              state, nstate;
    logic [CNT_W-1:0]  in_cnt, out_cnt;
    logic [BYTE_W-1:0] in_buf  [ENC_IN_BYTES];
    logic [BYTE_W-1:0] out_buf [DEC_OUT_BYTES];
    logic              mode_q, chg;
    logic              wr_acc, rd_acc, irq_n, go;
    logic [CNT_W-1:0]  last_in, last_out;
    logic [SMP_W-1:0]  c_smp_in, c_smp_out;
    logic [CODE_W-1:0] c_code_in, c_code_out;
    codec_st_t         cstate;

    sbc_mode_det u_mode (.clk(clk), .sel(sel_decode), .mode_q(mode_q), .chg(chg));

    assign go = ((state == ST_CALC0) || (state == ST_CALC1)) && !chg;

    sbc_codec u_codec (
        .clk(clk), .rst(rst), .clear(chg), .go(go), .dec(mode_q),
        .smp_in(c_smp_in), .code_in(c_code_in),
        .code_out(c_code_out), .smp_out(c_smp_out), .state_o(cstate)
    );

    always_comb begin
        last_in   = mode_q ? '0 : ENC_LAST_IN;
        last_out  = mode_q ? DEC_LAST_OUT : '0;
        c_smp_in  = (state == ST_CALC0) ? {in_buf[1], in_buf[0]} : {in_buf[3], in_buf[2]};
        c_code_in = (state == ST_CALC0) ? in_buf[0][3:0] : in_buf[0][7:4];
        wr_acc    = (state == ST_FILL)  && wr_stb && !chg;
        rd_acc    = (state == ST_DRAIN) && rd_stb && !chg;
        nstate    = state;
        if (chg) nstate = ST_FILL;
        else begin
            case (state)
                ST_FILL:  if (wr_acc && in_cnt == last_in)  nstate = ST_CALC0;
                ST_CALC0: nstate = ST_CALC1;
                ST_CALC1: nstate = ST_DRAIN;
                ST_DRAIN: if (rd_acc && out_cnt == last_out) nstate = ST_FILL;
                default:  nstate = ST_FILL;
            endcase
        end
        irq_n   = !(wr_stb || rd_stb) && ((nstate == ST_FILL) || (nstate == ST_DRAIN));
        rd_data = (state == ST_DRAIN) ? out_buf[out_cnt] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_FILL;
            in_cnt  <= '0;
            out_cnt <= '0;
            irq     <= 1'b0;
            for (int i = 0; i < ENC_IN_BYTES; i++)  in_buf[i]  <= '0;
            for (int i = 0; i < DEC_OUT_BYTES; i++) out_buf[i] <= '0;
        end else begin
            state <= nstate;
            irq   <= irq_n;
            if (chg) begin
                in_cnt  <= '0;
                out_cnt <= '0;
            end else begin
                if (wr_acc) begin
                    in_buf[in_cnt] <= wr_data;
                    in_cnt <= (in_cnt == last_in) ? '0 : in_cnt + 1'b1;
                end
                if (rd_acc)
                    out_cnt <= (out_cnt == last_out) ? '0 : out_cnt + 1'b1;
                if (state == ST_CALC0) begin
                    if (mode_q) {out_buf[1], out_buf[0]} <= c_smp_out;
                    else        out_buf[0][3:0]          <= c_code_out;
                end
                if (state == ST_CALC1) begin
                    if (mode_q) {out_buf[3], out_buf[2]} <= c_smp_out;
                    else        out_buf[0][7:4]          <= c_code_out;
                end
            end
        end
    end
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk
    import sbc_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sel_decode,
    input logic      wr_stb,
    input logic      rd_stb,
    input logic      irq,
    input seq_t      state,
    input codec_st_t cstate
);
    AST_IRQ_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        (wr_stb || rd_stb) |=> !irq);                                          // R6

    AST_CALC_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_CALC0) || (state == ST_CALC1)) |-> !irq);                // R6

    AST_TOGGLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sel_decode != $past(sel_decode)) |=> (cstate == '0));                 // R5

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        cstate.idx <= IDX_W'(IDX_MAX));                                        // R3

    AST_TOGGLE_REFILL: assert property (@(posedge clk) disable iff (rst)
        (sel_decode != $past(sel_decode)) |=> (state == ST_FILL));             // R5
endmodule

bind speech_byte_coder sbc_chk u_chk (
    .clk(clk), .rst(rst), .sel_decode(sel_decode), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .irq(irq), .state(state), .cstate(cstate)
);

// File: tb/speech_byte_coder_test.sv
`timescale 1ns/1ps
module speech_byte_coder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_decode = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int m_pred = 0;
    int m_idx  = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    speech_byte_coder uut (
        .clk(clk), .rst(rst), .sel_decode(sel_decode), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int bstep(input int i);
        return (4 + i % 4) << (i / 4);
    endfunction

    // Independent model of R3
    task automatic model_apply(input int c);
        int st, vp;
        st = bstep(m_idx);
        vp = st / 8;
        if ((c & 4) != 0) vp += st;
        if ((c & 2) != 0) vp += st / 2;
        if ((c & 1) != 0) vp += st / 4;
        m_pred = ((c & 8) != 0) ? m_pred - vp : m_pred + vp;
        if (m_pred > 32767)  m_pred = 32767;
        if (m_pred < -32768) m_pred = -32768;
        if ((c & 4) != 0) m_idx += 2 * ((c & 3) + 1);
        else              m_idx -= 1;
        if (m_idx < 0)  m_idx = 0;
        if (m_idx > 51) m_idx = 51;
    endtask

    task automatic model_enc(input int s, output int c);
        int d, mag, st;
        st = bstep(m_idx);
        d = s - m_pred;
        c = (d < 0) ? 8 : 0;
        mag = (d < 0) ? -d : d;
        if (mag >= st)     begin c |= 4; mag -= st; end
        if (mag >= st / 2) begin c |= 2; mag -= st / 2; end
        if (mag >= st / 4) c |= 1;
        model_apply(c);
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 20) begin @(negedge clk); n++; end
        check(irq == 1'b1, req, int'(irq), 1);
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_data = b;
        wr_stb  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
        check(irq == 1'b0, "R6 irq low after write", int'(irq), 0);
    endtask

    task automatic read_byte(input string req);
        logic [7:0] e;
        check(irq == 1'b1, "R6 irq high with output", int'(irq), 1);
        e = exp_q.pop_front();
        check(rd_data == e, req, int'(rd_data), int'(e));
        rd_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
        check(irq == 1'b0, "R6 irq low after read", int'(irq), 0);
    endtask

    task automatic latency_check();
        @(negedge clk);
        check(irq == 1'b0, "R6 irq low while computing", int'(irq), 0);
        @(negedge clk);
        check(irq == 1'b1, "R6 result due two cycles after last byte", int'(irq), 1);
    endtask

    // Scoreboard driver: compress transaction (R1, R4)
    task automatic enc_txn(input int s0, input int s1);
        int c0, c1;
        model_enc(s0, c0);
        model_enc(s1, c1);
        exp_q.push_back(8'((c1 << 4) | c0));
        wait_irq("R6 ready for input");
        write_byte(8'(s0));
        @(negedge clk); write_byte(8'(s0 >> 8));
        @(negedge clk); write_byte(8'(s1));
        @(negedge clk); write_byte(8'(s1 >> 8));
        latency_check();
        read_byte("R1 packed codes");
    endtask

    // Scoreboard driver: expand transaction (R2, R4)
    task automatic dec_txn(input logic [7:0] b, input int nread);
        model_apply(int'(b[3:0]));
        exp_q.push_back(8'(m_pred)); exp_q.push_back(8'(m_pred >> 8));
        model_apply(int'(b[7:4]));
        exp_q.push_back(8'(m_pred)); exp_q.push_back(8'(m_pred >> 8));
        wait_irq("R6 ready for input");
        write_byte(b);
        latency_check();
        for (int k = 0; k < nread; k++) begin
            if (k > 0) @(negedge clk);
            read_byte("R2 decoded sample bytes");
        end
    endtask

    task automatic toggle_mode(input logic m);
        sel_decode = m;
        @(posedge clk);
        @(negedge clk);
        check(irq == 1'b1, "R5 toggle returns to input", int'(irq), 1);
        m_pred = 0;
        m_idx  = 0;
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(irq == 1'b0, "R9 irq low in reset", int'(irq), 0);
        check(rd_data == 8'h00, "R9 rd_data zero in reset", int'(rd_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check(irq == 1'b1, "R9 irq high after reset", int'(irq), 1);

        // R1/R3: small positive, negative and saturating inputs; R8 stream continuity
        enc_txn(100, 100);
        enc_txn(-100, -100);
        enc_txn(32767, 32767);
        enc_txn(-32768, 32767);
        for (int i = 0; i < 12; i++) enc_txn((i * 5311) % 30000 - 15000, (i % 2) ? 20000 : -20000);

        // R7: read strobe while collecting input is ignored
        begin
            int c0, c1;
            model_enc(1234, c0);
            model_enc(-4321, c1);
            exp_q.push_back(8'((c1 << 4) | c0));
            wait_irq("R6 ready");
            write_byte(8'(1234));
            @(negedge clk); rd_stb = 1'b1; @(posedge clk); @(negedge clk); rd_stb = 1'b0;
            check(rd_data == 8'h00, "R7 no output while collecting", int'(rd_data), 0);
            @(negedge clk); write_byte(8'(1234 >> 8));
            @(negedge clk); write_byte(8'(-4321));
            @(negedge clk); write_byte(8'(-4321 >> 8));
            latency_check();
            // R7: write strobe while output pending is ignored
            wr_data = 8'hA5; wr_stb = 1'b1; @(posedge clk); @(negedge clk); wr_stb = 1'b0;
            @(negedge clk);
            read_byte("R7 output intact after stray write");
        end
        enc_txn(500, 600);

        // R5: abort a partial compress transaction by switching to expand
        wait_irq("R6 ready");
        write_byte(8'h34);
        @(negedge clk); write_byte(8'h12);
        @(negedge clk);
        toggle_mode(1'b1);

        // R2/R4: expand from cleared state, R8 continuity, saturation and index clamp
        dec_txn(8'h77, 4);
        dec_txn(8'hF8, 4);
        for (int i = 0; i < 10; i++) dec_txn(8'h77, 4);
        dec_txn(8'hFF, 4);
        dec_txn(8'h08, 4);

        // R5: abort after two of four reads, then compress from cleared state
        dec_txn(8'h5A, 2);
        @(negedge clk);
        toggle_mode(1'b0);
        check(rd_data == 8'h00, "R5 unread output discarded", int'(rd_data), 0);
        enc_txn(100, 100);
        enc_txn(-3000, 3000);

        // R5: expand after toggle decodes from zero
        toggle_mode(1'b1);
        dec_txn(8'h7F, 4);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule